// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address of every beat of one DRAM burst. A start strobe loads a 9-bit starting column together with a burst length code and a wrap-order select. From the next cycle on, the block presents one column per clock with a valid flag. On the final beat of a fixed-length burst it also raises a last-beat flag.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned block that holds the starting column. The low bits of the address move in sequential (add) or interleaved (XOR) order, and the upper bits stay the same. A full-page burst steps through the whole 512-column row, wraps from 511 to 0, and runs until a stop or interrupt ends it. A new start strobe on any cycle restarts the sequence.

The controller has three states:
- **IDLE**: no burst.
- **FIXED**: a counted burst.
- **PAGE**: an open-ended row burst.

Its transitions are:
- IDLE→FIXED or IDLE→PAGE on a start, chosen by the length code.
- FIXED→IDLE after the last beat.
- FIXED or PAGE→IDLE on stop or interrupt.
- FIXED or PAGE→FIXED or PAGE on a restart by a new start.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is asserted and after it is released with no start, `valid_o`, `last_o` and `col_o` are all 0.
- R2: When `start_i` is sampled high at a clock edge, `valid_o` is 1 and `col_o` equals the sampled `start_col_i` from that edge until the next edge.
- R3: Length code `len_code_i` maps 3'b000→1 beat, 3'b001→2, 3'b010→4, 3'b011→8 and 3'b111→full page. A fixed burst shows `valid_o` for exactly that many consecutive cycles, then drops it.
- R4: With `ilv_i`=0 (sequential), beat i of a fixed burst of length BL has low log2(BL) bits equal to (start + i) mod BL. The upper bits equal those of the start column.
- R5: With `ilv_i`=1 (interleaved), beat i of a fixed burst has low log2(BL) bits equal to the start's low bits XOR i. The upper bits are unchanged.
- R6: `last_o` is 1 on the final beat of a fixed burst and 0 on every other cycle.
- R7: In full-page mode `col_o` increases by one per cycle modulo 512 and ignores `ilv_i`. `last_o` stays 0 and the burst never ends by itself.
- R8: When `stop_i` is sampled high during a burst with no start in the same cycle, `valid_o` is 0 on the next cycle. This holds for every length, full page included.
- R9: `intr_i` sampled high during a burst with no start in the same cycle ends the burst in the same way as `stop_i`.
- R10: A start during a running burst restarts the sequence from the new column on the next cycle. A start wins over a stop or interrupt sampled in the same cycle.
- R11: Length code and wrap order are sampled only with the start strobe. Changes on those inputs during a burst have no effect on the columns it produces.
- R12: The reserved length codes 3'b100, 3'b101 and 3'b110 produce a single-beat burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start (or restart) a burst |
| start_col_i | input | 9 | Starting column, sampled with start_i |
| len_code_i | input | 3 | Burst length code, sampled with start_i |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential, sampled with start_i |
| stop_i | input | 1 | Burst stop |
| intr_i | input | 1 | Burst interrupt |
| col_o | output | 9 | Column of the current beat |
| valid_o | output | 1 | A beat is present this cycle |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
A wrong latched mask or a wrong wrap order shows up on `col_o` at the first beat where the low bits wrap. A beat counter that slips or fails to clear shows at once as a wrong second column, or as `last_o` on the wrong cycle. A state stuck in FIXED or PAGE shows as `valid_o` still high one cycle after the last beat or a stop. The bench compares every beat of every burst, so each of these faults is visible within one to eight cycles of its cause. A broken 511-to-0 wrap shows at the first page wrap.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
    localparam int LEN_CODE_W = 3;

    localparam logic [LEN_CODE_W-1:0] LEN_ONE   = 3'b000;
    localparam logic [LEN_CODE_W-1:0] LEN_TWO   = 3'b001;
    localparam logic [LEN_CODE_W-1:0] LEN_FOUR  = 3'b010;
    localparam logic [LEN_CODE_W-1:0] LEN_EIGHT = 3'b011;
    localparam logic [LEN_CODE_W-1:0] LEN_PAGE  = 3'b111;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_PAGE  = 2'd2
    } bcg_state_e;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
    import bcg_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [LEN_CODE_W-1:0] code_i,
    output logic [COL_W-1:0]      mask_o,
    output logic                  page_o
);
    // The mask marks the column bits that move within the burst.
    always_comb begin
        mask_o = '0;
        page_o = 1'b0;
        case (code_i)
            LEN_TWO:   mask_o = COL_W'(1);
            LEN_FOUR:  mask_o = COL_W'(3);
            LEN_EIGHT: mask_o = COL_W'(7);
            LEN_PAGE: begin
                mask_o = '1;
                page_o = 1'b1;
            end
            default:   mask_o = '0; // single beat and reserved codes
        endcase
    end
endmodule

// File: rtl/bcg_beat_ctr.sv
module bcg_beat_ctr #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             adv_i,
    output logic [COL_W-1:0] beat_o
);
    logic [COL_W-1:0] beat_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            beat_q <= '0;
        else if (clear_i)
            beat_q <= '0;
        else if (adv_i)
            beat_q <= beat_q + COL_W'(1);
    end

    assign beat_o = beat_q;
endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] sum;

    assign sum = base_i + beat_i;

    // Each bit either stays at the base or takes the sum or XOR form.
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col_o[b] = mask_i[b] ? (ilv_i ? (base_i[b] ^ beat_i[b]) : sum[b])
                                    : base_i[b];
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [COL_W-1:0]      start_col_i,
    input  logic [LEN_CODE_W-1:0] len_code_i,
    input  logic                  ilv_i,
    input  logic                  stop_i,
    input  logic                  intr_i,
    output logic [COL_W-1:0]      col_o,
    output logic                  valid_o,
    output logic                  last_o
);
    bcg_state_e       state_q, state_d;
    logic [COL_W-1:0] base_q, mask_q;
    logic             ilv_q;
    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] map_col;
    logic             on_last;
    logic             halt;

    bcg_len_decode #(.COL_W(COL_W)) u_dec (
        .code_i (len_code_i),
        .mask_o (dec_mask),
        .page_o (dec_page)
    );

    bcg_beat_ctr #(.COL_W(COL_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_i),
        .adv_i   (state_q != ST_IDLE),
        .beat_o  (beat)
    );

    bcg_addr_map #(.COL_W(COL_W)) u_map (
        .base_i (base_q),
        .beat_i (beat),
        .mask_i (mask_q),
        .ilv_i  (ilv_q),
        .col_o  (map_col)
    );

    assign on_last = (state_q == ST_FIXED) && (beat == mask_q);
    assign halt    = stop_i || intr_i;

    // Burst parameters are latched only with the start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            ilv_q  <= 1'b0;
        end else if (start_i) begin
            base_q <= start_col_i;
            mask_q <= dec_mask;
            ilv_q  <= ilv_i && !dec_page;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = dec_page ? ST_PAGE : ST_FIXED;
        end else if (halt) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_FIXED: state_d = on_last ? ST_IDLE : ST_FIXED;
                ST_PAGE:  state_d = ST_PAGE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // Output logic
    always_comb begin
        col_o   = '0;
        valid_o = 1'b0;
        last_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FIXED: begin
                col_o   = map_col;
                valid_o = 1'b1;
                last_o  = on_last;
            end
            ST_PAGE: begin
                col_o   = map_col;
                valid_o = 1'b1;
            end
            default: ;
        endcase
    end

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o && (col_o == $past(start_col_i))); // R2

    AST_HALT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && halt && !start_i) |=> !valid_o); // R8

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o); // R6

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && !start_i && !halt) |=>
        (valid_o && ((col_o & ~mask_q) == ($past(col_o) & ~$past(mask_q))))); // R4

    AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAGE && col_o == '1 && !start_i && !halt) |=>
        (valid_o && col_o == '0 && !last_o)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (!last_o && col_o == '0)); // R1
endmodule

// File: tb/tb_burst_col_gen.sv
`timescale 1ns/1ps
module tb_burst_col_gen;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i;
    logic [8:0] start_col_i;
    logic [2:0] len_code_i;
    logic       ilv_i;
    logic       stop_i;
    logic       intr_i;
    logic [8:0] col_o;
    logic       valid_o;
    logic       last_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    burst_col_gen dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .len_code_i  (len_code_i),
        .ilv_i       (ilv_i),
        .stop_i      (stop_i),
        .intr_i      (intr_i),
        .col_o       (col_o),
        .valid_o     (valid_o),
        .last_o      (last_o)
    );

    typedef struct packed {
        logic [8:0]      col;
        logic [2:0]      code;
        logic            ilv;
        logic [3:0]      n;
        logic [0:7][8:0] exp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{9'h10D, 3'b011, 1'b0, 4'd8, {9'h10D, 9'h10E, 9'h10F, 9'h108, 9'h109, 9'h10A, 9'h10B, 9'h10C}},
        '{9'h10D, 3'b011, 1'b1, 4'd8, {9'h10D, 9'h10C, 9'h10F, 9'h10E, 9'h109, 9'h108, 9'h10B, 9'h10A}},
        '{9'h0A3, 3'b010, 1'b0, 4'd4, {9'h0A3, 9'h0A0, 9'h0A1, 9'h0A2, 9'h0, 9'h0, 9'h0, 9'h0}},
        '{9'h0A2, 3'b010, 1'b1, 4'd4, {9'h0A2, 9'h0A3, 9'h0A0, 9'h0A1, 9'h0, 9'h0, 9'h0, 9'h0}},
        '{9'h1FF, 3'b001, 1'b0, 4'd2, {9'h1FF, 9'h1FE, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0}},
        '{9'h1FF, 3'b001, 1'b1, 4'd2, {9'h1FF, 9'h1FE, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0}},
        '{9'h055, 3'b000, 1'b0, 4'd1, {9'h055, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0}},
        '{9'h0C4, 3'b101, 1'b1, 4'd1, {9'h0C4, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0}},
        '{9'h0C7, 3'b110, 1'b0, 4'd1, {9'h0C7, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0}}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic launch(input logic [8:0] c, input logic [2:0] code, input logic il);
        start_i     = 1'b1;
        start_col_i = c;
        len_code_i  = code;
        ilv_i       = il;
        tick();
        start_i     = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; start_col_i = '0; len_code_i = '0;
        ilv_i = 1'b0; stop_i = 1'b0; intr_i = 1'b0;
        tick(); tick();
        // R1: outputs quiet in reset
        chk("R1 valid in reset", valid_o, 0);
        chk("R1 last in reset", last_o, 0);
        chk("R1 col in reset", col_o, 0);
        rst_n = 1'b1;
        tick();
        chk("R1 valid after reset", valid_o, 0);
        chk("R1 col after reset", col_o, 0);

        // Table walk: R2 R3 R4 R5 R6 R12
        for (int v = 0; v < NV; v++) begin
            launch(VECS[v].col, VECS[v].code, VECS[v].ilv);
            for (int i = 0; i < int'(VECS[v].n); i++) begin
                chk("R3 valid during burst", valid_o, 1);
                chk(VECS[v].ilv ? "R5 R12 column order" : "R4 R2 column order",
                    col_o, VECS[v].exp[i]);
                chk("R6 last flag", last_o, (i == int'(VECS[v].n) - 1) ? 1 : 0);
                tick();
            end
            chk("R3 burst ends", valid_o, 0);
            tick();
        end

        // R7: full page, interleave ignored, wraps, never last
        launch(9'h1FD, 3'b111, 1'b1);
        chk("R7 page beat0", col_o, 9'h1FD); tick();
        chk("R7 page beat1", col_o, 9'h1FE); tick();
        chk("R7 page beat2", col_o, 9'h1FF); tick();
        chk("R7 page wrap", col_o, 9'h000); tick();
        chk("R7 page beat4", col_o, 9'h001);
        chk("R7 page no last", last_o, 0);
        for (int i = 4; i < 512; i++) tick();
        chk("R7 page full row", col_o, 9'h1FD);
        chk("R7 page still valid", valid_o, 1);
        chk("R7 page no last after row", last_o, 0);
        // R8: stop in full page
        stop_i = 1'b1; tick(); stop_i = 1'b0;
        chk("R8 stop ends page", valid_o, 0);
        tick();

        // R9: interrupt a fixed burst after three beats
        launch(9'h040, 3'b011, 1'b0);
        tick(); tick();
        chk("R9 before interrupt", col_o, 9'h042);
        intr_i = 1'b1; tick(); intr_i = 1'b0;
        chk("R9 interrupt ends burst", valid_o, 0);
        tick();

        // R8: stop on first beat of fixed burst
        launch(9'h013, 3'b010, 1'b1);
        stop_i = 1'b1; tick(); stop_i = 1'b0;
        chk("R8 stop fixed", valid_o, 0);
        tick();

        // R10: restart with simultaneous stop
        launch(9'h148, 3'b011, 1'b0);
        tick();
        chk("R10 running", col_o, 9'h149);
        stop_i = 1'b1;
        launch(9'h020, 3'b010, 1'b0);
        stop_i = 1'b0;
        chk("R10 restart valid", valid_o, 1);
        chk("R10 restart col", col_o, 9'h020); tick();
        chk("R10 restart beat1", col_o, 9'h021); tick();
        chk("R10 restart beat2", col_o, 9'h022); tick();
        chk("R10 restart beat3", col_o, 9'h023);
        chk("R10 restart last", last_o, 1); tick();
        chk("R10 restart ends", valid_o, 0);
        tick();

        // R11: length and order changes mid-burst ignored
        launch(9'h031, 3'b010, 1'b0);
        len_code_i = 3'b111; ilv_i = 1'b1;
        chk("R11 beat0", col_o, 9'h031); tick();
        chk("R11 beat1", col_o, 9'h032); tick();
        chk("R11 beat2", col_o, 9'h033); tick();
        chk("R11 beat3", col_o, 9'h030);
        chk("R11 last", last_o, 1); tick();
        chk("R11 ends", valid_o, 0);
        chk("R1 idle col", col_o, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule